// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a two-wire synchronous link. It drives a shift clock and a single data line that carries data in both directions, but only one direction is used at a time. Writing a byte to the transmit input sends it out, least significant bit first. Clearing the receive-done flag while reception is enabled starts an 8-bit capture from the same data line.

The block advances only on cycles where the oscillator-rate enable is high. One shift-clock period lasts twelve of those ticks. The clock stays low for ten ticks and high for two. Outgoing data changes only when the clock falls, so each bit is stable ten ticks before the rising edge and two ticks after it. Incoming data is captured on the tick where the clock rises. A done flag for each direction is raised when the eighth bit period ends.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data output enable is low, and both done flags are low.
- R2: A write on `txWrite` while idle starts a transmit of `txData`. `dataOe` is high for the whole transfer, and bit k (bit 0 first) is on `dataOut` during bit period k.
- R3: Each bit period lasts 12 enable ticks. The shift clock is low for the first 10 ticks and high for the last 2. The output bit changes only at the start of a period.
- R4: On the enable tick that ends the eighth period of a transmit, `txDone` goes high, the shift clock returns high and `dataOe` goes low (96 ticks after the start).
- R5: A pulse on `rxFlagClear` while `rxEnable` is high and the port is idle starts a reception. `dataOe` stays low throughout.
- R6: During reception `dataIn` is captured on the tick where the shift clock rises, least significant bit first. When the eighth period ends, `rxDone` goes high and `rxData` holds the received byte.
- R7: A write on `txWrite` while a transfer is running is ignored. The running byte and its timing continue unchanged.
- R8: A pulse on `rxFlagClear` while `rxEnable` is low clears `rxDone` and starts nothing. The shift clock stays high and `dataOe` stays low.
- R9: The port advances only on cycles where `oscEn` is high. With `oscEn` low, the clock level, the output bit and the flags hold.
- R10: `txDoneClear` clears `txDone`, and starting a new transmit also clears it. A transmit start takes priority over a simultaneous reception start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscEn | input | 1 | Oscillator-rate tick enable |
| txWrite | input | 1 | Transmit buffer write strobe |
| txData | input | 8 | Byte to transmit |
| txDoneClear | input | 1 | Clears the transmit-done flag |
| rxEnable | input | 1 | Allows a reception to start |
| rxFlagClear | input | 1 | Clears the receive-done flag, and starts a reception when allowed |
| dataIn | input | 1 | Data line as read from the pin |
| sclk | output | 1 | Shift clock, high when idle |
| dataOut | output | 1 | Data line drive value |
| dataOe | output | 1 | Data line output enable |
| txDone | output | 1 | Transmit complete flag |
| rxDone | output | 1 | Receive complete flag |
| rxData | output | 8 | Received byte |

## Verification
The hardest case to reach from the ports is a second transmit write that lands in the middle of a running byte. The bench injects that write at a chosen tick inside a transfer, with a different byte on `txData`. It then checks every remaining tick of the waveform against the original byte. To check the receive side, the bench changes `dataIn` just after each rising clock edge. A sample taken on any other tick would then pick up the wrong bit. Holding `oscEn` low right after a start freezes the port in its first tick, which exposes any logic that advances without the enable.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture the transmit byte
    logic shiftTx;   // advance to the next outgoing bit
    logic sampleRx;  // shift the data input in
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PERIOD     = 12,
  parameter int HIGH_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscEn,
  input  logic       txWrite,
  input  logic       txDoneClear,
  input  logic       rxEnable,
  input  logic       rxFlagClear,
  output sspStrobe_t strb,
  output logic       sclkOut,
  output logic       dataOe,
  output logic       txDone,
  output logic       rxDone
);
  localparam int PH_W    = $clog2(PERIOD);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int RISE_PH = PERIOD - HIGH_TICKS;

  logic             active;
  logic             isRx;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitCnt;

  logic startTx, startRx, tick, riseTick, endTick, lastBit, finish;

  always_comb begin
    startTx  = txWrite & ~active;
    startRx  = rxFlagClear & rxEnable & ~active & ~txWrite;
    tick     = oscEn & active;
    riseTick = tick & (phase == PH_W'(RISE_PH - 1));
    endTick  = tick & (phase == PH_W'(PERIOD - 1));
    lastBit  = (bitCnt == BIT_W'(DATA_W - 1));
    finish   = endTick & lastBit;
    strb.load     = startTx;
    strb.shiftTx  = endTick & ~isRx;
    strb.sampleRx = riseTick & isRx;
    sclkOut = ~active | (phase >= PH_W'(RISE_PH));
    dataOe  = active & ~isRx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      isRx   <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
    end else if (startTx || startRx) begin
      active <= 1'b1;
      isRx   <= startRx;
      phase  <= '0;
      bitCnt <= '0;
    end else if (tick) begin
      if (endTick) begin
        phase  <= '0;
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) active <= 1'b0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDone <= 1'b0;
      rxDone <= 1'b0;
    end else begin
      if (finish && !isRx)              txDone <= 1'b1;
      else if (txDoneClear || startTx)  txDone <= 1'b0;
      if (finish && isRx)               rxDone <= 1'b1;
      else if (rxFlagClear)             rxDone <= 1'b0;
    end
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    phase < PH_W'(PERIOD));
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (active && !oscEn && !txWrite && !rxFlagClear) |=> ($stable(phase) && $stable(bitCnt)));
  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> (!active && $past(active)));
  assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && txWrite) |=> $stable(isRx));
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobe_t        strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              dataIn,
  output logic [DATA_W-1:0] shiftReg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '1;
    else if (strb.load)     shiftReg <= txData;
    else if (strb.sampleRx) shiftReg <= {dataIn, shiftReg[DATA_W-1:1]};
    else if (strb.shiftTx)  shiftReg <= {1'b1, shiftReg[DATA_W-1:1]};
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shiftTx, strb.sampleRx}));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(shiftReg));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PERIOD     = 12,
  parameter int HIGH_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscEn,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              txDoneClear,
  input  logic              rxEnable,
  input  logic              rxFlagClear,
  input  logic              dataIn,
  output logic              sclk,
  output logic              dataOut,
  output logic              dataOe,
  output logic              txDone,
  output logic              rxDone,
  output logic [DATA_W-1:0] rxData
);
  sspStrobe_t        strb;
  logic [DATA_W-1:0] shiftReg;

  ssp_ctrl #(.DATA_W(DATA_W), .PERIOD(PERIOD), .HIGH_TICKS(HIGH_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .txWrite(txWrite),
    .txDoneClear(txDoneClear), .rxEnable(rxEnable), .rxFlagClear(rxFlagClear),
    .strb(strb), .sclkOut(sclk), .dataOe(dataOe), .txDone(txDone), .rxDone(rxDone)
  );

  ssp_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData),
    .dataIn(dataIn), .shiftReg(shiftReg)
  );

  assign dataOut = shiftReg[0] | ~dataOe;
  assign rxData  = shiftReg;

  assert_rx_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleRx |-> !dataOe);
  assert_sample_on_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleRx |=> $rose(sclk));
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> (sclk && !dataOe));
endmodule

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {isRx, pattern}
  localparam logic [8:0] VECS [NVEC] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h01}, {1'b1, 8'h3C},
    {1'b1, 8'h80}, {1'b0, 8'hFF}, {1'b1, 8'h00}};

  logic clk = 1'b0, rstN = 1'b0, oscEn = 1'b1;
  logic txWrite = 1'b0, txDoneClear = 1'b0, rxEnable = 1'b1, rxFlagClear = 1'b0;
  logic dataIn = 1'b1;
  logic [7:0] txData = 8'h00;
  logic sclk, dataOut, dataOe, txDone, rxDone;
  logic [7:0] rxData;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_shift_port dut (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .txWrite(txWrite), .txData(txData),
    .txDoneClear(txDoneClear), .rxEnable(rxEnable), .rxFlagClear(rxFlagClear),
    .dataIn(dataIn), .sclk(sclk), .dataOut(dataOut), .dataOe(dataOe),
    .txDone(txDone), .rxDone(rxDone), .rxData(rxData));

  task automatic check(input logic cond, input string req, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // run one transfer; intrudeAt = tick index at which a stray write is injected (-1 none)
  task automatic runXfer(input logic rx, input logic [7:0] pat, input int intrudeAt, input string tag);
    logic ok = 1'b1;
    int firstBad = -1;
    if (rx) begin dataIn = pat[0]; rxFlagClear = 1'b1; end
    else begin txData = pat; txWrite = 1'b1; end
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 12; p++) begin
        @(negedge clk);
        txWrite = 1'b0; rxFlagClear = 1'b0; txData = pat;
        if (k * 12 + p == intrudeAt) begin txWrite = 1'b1; txData = ~pat; end
        if (sclk !== (p >= 10)) ok = 1'b0;
        if (dataOe !== !rx) ok = 1'b0;
        if (!rx && dataOut !== pat[k]) ok = 1'b0;
        if (!rx && txDone !== 1'b0) ok = 1'b0;
        if (rx && rxDone !== 1'b0) ok = 1'b0;
        if (!ok && firstBad < 0) firstBad = k * 12 + p;
        if (rx && p == 10 && k < 7) dataIn = pat[k + 1];
      end
    end
    txWrite = 1'b0;
    check(ok, {tag, " waveform, first bad tick"}, firstBad, -1);
    @(negedge clk);
    if (rx) begin
      check(rxDone === 1'b1 && dataOe === 1'b0 && sclk === 1'b1, "R6 rxDone at end", rxDone, 1);
      check(rxData === pat, "R6 received byte", rxData, pat);
    end else begin
      check(txDone === 1'b1 && dataOe === 1'b0 && sclk === 1'b1, "R4 txDone at end",
            {txDone, dataOe, sclk}, 3'b101);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nChecks, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    check(sclk === 1'b1 && dataOe === 1'b0 && txDone === 1'b0 && rxDone === 1'b0,
          "R1 reset state", {sclk, dataOe, txDone, rxDone}, 4'b1000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1 && dataOe === 1'b0, "R1 idle after reset", {sclk, dataOe}, 2'b10);

    // table of vectors (R2 R3 transmit, R5 R6 receive)
    for (int v = 0; v < NVEC; v++) begin
      runXfer(VECS[v][8], VECS[v][7:0], -1, VECS[v][8] ? "R5 R6 R3" : "R2 R3");
      @(negedge clk);
    end

    // R8: clear with receive disabled starts nothing
    rxEnable = 1'b0; rxFlagClear = 1'b1;
    begin
      logic quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); rxFlagClear = 1'b0;
        if (sclk !== 1'b1 || dataOe !== 1'b0) quiet = 1'b0;
      end
      check(quiet, "R8 no reception started", {sclk, dataOe}, 2'b10);
      check(rxDone === 1'b0, "R8 rxDone cleared", rxDone, 0);
    end
    rxEnable = 1'b1;

    // R10: explicit clear of txDone (set by earlier 8'hFF transmit)
    check(txDone === 1'b1, "R10 txDone still set", txDone, 1);
    txDoneClear = 1'b1; @(negedge clk); txDoneClear = 1'b0;
    check(txDone === 1'b0, "R10 txDone cleared", txDone, 0);

    // R7: stray writes during a transfer
    runXfer(1'b0, 8'hC3, 30, "R7");
    @(negedge clk);
    runXfer(1'b0, 8'h5A, 95, "R7 late");
    @(negedge clk);

    // R10: simultaneous starts, transmit wins
    txData = 8'h69; txWrite = 1'b1; rxFlagClear = 1'b1;
    @(negedge clk); txWrite = 1'b0; rxFlagClear = 1'b0;
    check(dataOe === 1'b1 && txDone === 1'b0 && dataOut === 1'b1,
          "R10 transmit priority and flag clear", {dataOe, txDone, dataOut}, 3'b101);
    for (int i = 0; i < 96; i++) @(negedge clk);
    check(txDone === 1'b1, "R10 priority transfer done", txDone, 1);

    // R9: frozen without oscillator ticks
    oscEn = 1'b0; txData = 8'h96; txWrite = 1'b1;
    @(negedge clk); txWrite = 1'b0;
    for (int i = 0; i < 30; i++) @(negedge clk);
    check(sclk === 1'b0 && dataOe === 1'b1 && dataOut === 1'b0 && txDone === 1'b0,
          "R9 held in first tick", {sclk, dataOe, dataOut, txDone}, 4'b0100);
    oscEn = 1'b1;
    for (int i = 0; i < 95; i++) @(negedge clk);
    check(txDone === 1'b0 && sclk === 1'b1 && dataOe === 1'b1, "R4 R9 one tick before end",
          {txDone, sclk, dataOe}, 3'b011);
    @(negedge clk);
    check(txDone === 1'b1 && dataOe === 1'b0, "R4 R9 done after 96 ticks", {txDone, dataOe}, 2'b10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule